// File: doc/BRIEF.md
# UART Channel Diagnostic Routing Switch

This block sits between a single UART channel's transmitter, receiver, serial pins, baud clocks and processor interface. A two-bit mode field picks one of four routings. Normal lets the transmitter and receiver run independently. Automatic echo sends received bits back out on the transmit pin. Local loopback turns the transmitter back into the receiver. Remote loopback echoes the line while hiding received data from the processor. For each routing, the block steers the serial bits, selects which baud clock each half uses, and gates the status and processor paths.

The mode field is registered, so a new mode takes effect on the next clock edge, even in the middle of a character. There is one exception. If an echo routing is left in the short window after the receiver has sampled a stop bit, and the transmitter is enabled, the echo routing on the transmit side is held until that stop bit has been sent out in full. The next receive bit tick marks that point. The transmitter, the receiver and the baud generators are outside the block.

Top module: `uart_mode_router`

## Requirements
- R1: After reset the mode is normal (code 00), the hold flag `echo_hold` is 0 and the echo register is at mark (1).
- R2: In normal mode (code 00), `txd_pin` follows `tx_serial` and `rx_serial_in` follows `rxd_pin`. No clock swap is selected. Transmit status, processor writes, received characters, error bits and checking all pass through unchanged.
- R3: A value on `mode_in` takes effect on the clock edge after it is applied. Before that edge, the outputs keep the routing of the previous mode.
- R4: In automatic echo (code 01) and remote loopback (code 11), `txd_pin` carries the level of `rxd_pin` captured at the most recent `rx_bit_tick`. This includes parity, stop and break levels, and no bit is regenerated. `tx_clk_from_rx` is 1.
- R5: In automatic echo, `tx_rdy`, `tx_emt` and `tx_wr` are forced to 0. Received characters, error bits and `rx_check_en` (1) pass to the processor side.
- R6: In local loopback (code 10), `rx_serial_in` equals `tx_serial` and `txd_pin` is held at 1 regardless of `rxd_pin`. `rx_clk_from_tx` is 1.
- R7: In remote loopback, `rx_char_to_cpu` is 0, `rx_err` is all zeros and `rx_check_en` is 0. Transmit status and writes are forced to 0.
- R8: Hold is set in either of two cases. In the first, an edge moves the registered mode from an echo code to a non-echo code while `rx_stop_seen` is 1. In the second, the same move happens after a stop tick and before the next `rx_bit_tick`, with `tx_en` at 1. While hold is set, `echo_hold` is 1 and the transmit side (`txd_pin`, `tx_clk_from_rx`, transmit status and write gating) keeps the old echo routing. The receive side follows the new mode. Hold clears at the next edge with `rx_bit_tick` at 1 and `rx_stop_seen` at 0.
- R9: Leaving an echo mode with `tx_en` at 0, or outside the stop window, switches the transmit side at once with no hold.
- R10: While `rx_en` is 0, the echo register is forced to mark (1), so the echo modes send 1.
- R11: Selecting an echo code on `mode_in` while hold is set clears hold at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_in | input | 2 | Routing select: 00 normal, 01 echo, 10 local loop, 11 remote loop |
| rxd_pin | input | 1 | Serial receive pin |
| tx_serial | input | 1 | Transmitter serial output |
| rx_bit_tick | input | 1 | Receiver sampled a bit this cycle |
| rx_stop_seen | input | 1 | Receiver sampled a stop bit this cycle (comes with a bit tick) |
| tx_en | input | 1 | Transmitter enabled |
| rx_en | input | 1 | Receiver enabled |
| tx_rdy_raw | input | 1 | Transmitter ready flag from the transmitter |
| tx_emt_raw | input | 1 | Transmitter empty flag from the transmitter |
| cpu_tx_wr | input | 1 | Processor write strobe to the transmit buffer |
| rx_char_valid | input | 1 | Receiver has a character for the processor |
| rx_err_raw | input | ERR_W | Receive error flags from the receiver |
| txd_pin | output | 1 | Serial transmit pin |
| rx_serial_in | output | 1 | Serial input fed to the receiver |
| tx_clk_from_rx | output | 1 | Transmitter runs on the receive baud clock |
| rx_clk_from_tx | output | 1 | Receiver runs on the transmit baud clock |
| tx_rdy | output | 1 | Gated transmitter ready flag |
| tx_emt | output | 1 | Gated transmitter empty flag |
| tx_wr | output | 1 | Gated processor write to the transmitter |
| rx_char_to_cpu | output | 1 | Gated received-character flag |
| rx_check_en | output | 1 | Parity and framing checks enabled |
| rx_err | output | ERR_W | Gated receive error flags |
| echo_hold | output | 1 | Deferred-exit hold is active |

## Verification
The hardest situation to reach is the deferred exit. It needs an echo mode, an enabled transmitter, a stop-bit sample, and a mode change that lands in the window before the next bit tick. The bench drives `rx_bit_tick` and `rx_stop_seen` itself, cycle by cycle. It can therefore place the mode change exactly on the stop-sample edge and in the idle cycles after it. It then repeats the same sequence with the transmitter disabled, with the change placed after an ordinary data tick, and with a return to an echo code during the hold.

// File: rtl/umr_pkg.sv
package umr_pkg;
  typedef enum logic [1:0] {
    UMR_NORMAL = 2'b00,
    UMR_ECHO   = 2'b01,
    UMR_LOCAL  = 2'b10,
    UMR_REMOTE = 2'b11
  } umr_mode_e;

  // True for the two routings that resend the received line.
  function automatic logic umr_is_echo(input logic [1:0] m);
    return (m == UMR_ECHO) || (m == UMR_REMOTE);
  endfunction

  // Exit that must be deferred: echo -> non-echo inside the stop window.
  function automatic logic umr_defer_exit(input logic [1:0] cur, input logic [1:0] nxt,
                                          input logic tx_on, input logic in_window);
    return umr_is_echo(cur) && !umr_is_echo(nxt) && tx_on && in_window;
  endfunction
endpackage

// File: rtl/umr_mode_ctrl.sv
module umr_mode_ctrl
  import umr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_in,
  input  logic       tx_en,
  input  logic       rx_bit_tick,
  input  logic       rx_stop_seen,
  output logic [1:0] mode_q,
  output logic [1:0] hold_mode_q,
  output logic       hold_q
);
  logic stop_win_q;
  logic defer_now;
  logic hold_release;

  assign defer_now    = umr_defer_exit(mode_q, mode_in, tx_en, stop_win_q || rx_stop_seen);
  assign hold_release = umr_is_echo(mode_in) || (rx_bit_tick && !rx_stop_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= UMR_NORMAL;
      hold_mode_q <= UMR_NORMAL;
      hold_q      <= 1'b0;
      stop_win_q  <= 1'b0;
    end else begin
      mode_q <= mode_in;
      if (rx_stop_seen)     stop_win_q <= 1'b1;
      else if (rx_bit_tick) stop_win_q <= 1'b0;
      if (defer_now) begin
        hold_q      <= 1'b1;
        hold_mode_q <= mode_q;
      end else if (hold_release) begin
        hold_q      <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/umr_echo_reg.sv
module umr_echo_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_pin,
  input  logic rx_bit_tick,
  input  logic rx_en,
  output logic echo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           echo_q <= 1'b1;
    else if (!rx_en)      echo_q <= 1'b1;
    else if (rx_bit_tick) echo_q <= rxd_pin;
  end
endmodule

// File: rtl/umr_path_mux.sv
module umr_path_mux
  import umr_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic [1:0]       tx_mode,
  input  logic [1:0]       rx_mode,
  input  logic             echo_q,
  input  logic             rxd_pin,
  input  logic             tx_serial,
  input  logic             tx_rdy_raw,
  input  logic             tx_emt_raw,
  input  logic             cpu_tx_wr,
  input  logic             rx_char_valid,
  input  logic [ERR_W-1:0] rx_err_raw,
  output logic             txd_pin,
  output logic             rx_serial_in,
  output logic             tx_clk_from_rx,
  output logic             rx_clk_from_tx,
  output logic             tx_rdy,
  output logic             tx_emt,
  output logic             tx_wr,
  output logic             rx_char_to_cpu,
  output logic             rx_check_en,
  output logic [ERR_W-1:0] rx_err
);
  logic tx_echo;
  logic rx_remote;

  assign tx_echo   = umr_is_echo(tx_mode);
  assign rx_remote = (rx_mode == UMR_REMOTE);

  always_comb begin
    unique case (tx_mode)
      UMR_LOCAL:            txd_pin = 1'b1;
      UMR_ECHO, UMR_REMOTE: txd_pin = echo_q;
      default:              txd_pin = tx_serial;
    endcase
  end

  assign rx_serial_in   = (rx_mode == UMR_LOCAL) ? tx_serial : rxd_pin;
  assign rx_clk_from_tx = (rx_mode == UMR_LOCAL);
  assign tx_clk_from_rx = tx_echo;
  assign tx_rdy         = tx_rdy_raw & ~tx_echo;
  assign tx_emt         = tx_emt_raw & ~tx_echo;
  assign tx_wr          = cpu_tx_wr  & ~tx_echo;
  assign rx_char_to_cpu = rx_char_valid & ~rx_remote;
  assign rx_check_en    = ~rx_remote;
  assign rx_err         = rx_remote ? '0 : rx_err_raw;
endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
  import umr_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_in,
  input  logic             rxd_pin,
  input  logic             tx_serial,
  input  logic             rx_bit_tick,
  input  logic             rx_stop_seen,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tx_rdy_raw,
  input  logic             tx_emt_raw,
  input  logic             cpu_tx_wr,
  input  logic             rx_char_valid,
  input  logic [ERR_W-1:0] rx_err_raw,
  output logic             txd_pin,
  output logic             rx_serial_in,
  output logic             tx_clk_from_rx,
  output logic             rx_clk_from_tx,
  output logic             tx_rdy,
  output logic             tx_emt,
  output logic             tx_wr,
  output logic             rx_char_to_cpu,
  output logic             rx_check_en,
  output logic [ERR_W-1:0] rx_err,
  output logic             echo_hold
);
  logic [1:0] mode_q;
  logic [1:0] hold_mode_q;
  logic       hold_q;
  logic       echo_q;
  logic [1:0] tx_side_mode;

  umr_mode_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .tx_en(tx_en),
    .rx_bit_tick(rx_bit_tick), .rx_stop_seen(rx_stop_seen),
    .mode_q(mode_q), .hold_mode_q(hold_mode_q), .hold_q(hold_q)
  );

  umr_echo_reg u_echo (
    .clk(clk), .rst_n(rst_n), .rxd_pin(rxd_pin),
    .rx_bit_tick(rx_bit_tick), .rx_en(rx_en), .echo_q(echo_q)
  );

  // Transmit half keeps the old echo routing while the hold is set.
  assign tx_side_mode = hold_q ? hold_mode_q : mode_q;
  assign echo_hold    = hold_q;

  umr_path_mux #(.ERR_W(ERR_W)) u_mux (
    .tx_mode(tx_side_mode), .rx_mode(mode_q), .echo_q(echo_q),
    .rxd_pin(rxd_pin), .tx_serial(tx_serial),
    .tx_rdy_raw(tx_rdy_raw), .tx_emt_raw(tx_emt_raw), .cpu_tx_wr(cpu_tx_wr),
    .rx_char_valid(rx_char_valid), .rx_err_raw(rx_err_raw),
    .txd_pin(txd_pin), .rx_serial_in(rx_serial_in),
    .tx_clk_from_rx(tx_clk_from_rx), .rx_clk_from_tx(rx_clk_from_tx),
    .tx_rdy(tx_rdy), .tx_emt(tx_emt), .tx_wr(tx_wr),
    .rx_char_to_cpu(rx_char_to_cpu), .rx_check_en(rx_check_en), .rx_err(rx_err)
  );
endmodule

// File: rtl/umr_checker.sv
module umr_checker #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_in,
  input logic             rxd_pin,
  input logic             tx_serial,
  input logic             rx_bit_tick,
  input logic             rx_stop_seen,
  input logic             tx_en,
  input logic             rx_en,
  input logic             txd_pin,
  input logic             rx_serial_in,
  input logic             tx_clk_from_rx,
  input logic             rx_clk_from_tx,
  input logic             tx_rdy,
  input logic             tx_emt,
  input logic             tx_wr,
  input logic             rx_char_to_cpu,
  input logic             rx_check_en,
  input logic [ERR_W-1:0] rx_err,
  input logic             echo_hold
);
  a_r3_local_clock_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b10) |=> rx_clk_from_tx);

  a_r4_echo_reclock: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b01 && rx_bit_tick && rx_en) |=> (txd_pin == $past(rxd_pin) && tx_clk_from_rx));

  a_r5_echo_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b01) |=> (!tx_rdy && !tx_emt && !tx_wr));

  a_r6_local_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b10) |=> (rx_serial_in == tx_serial && (echo_hold || txd_pin)));

  a_r7_remote_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b11) |=> (!rx_char_to_cpu && rx_err == '0 && !rx_check_en));

  a_r8_hold_keeps_echo_clock: assert property (@(posedge clk) disable iff (!rst_n)
    echo_hold |-> (tx_clk_from_rx && !tx_wr));

  a_r8_hold_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_hold && rx_bit_tick && !rx_stop_seen) |=> !echo_hold);

  a_r9_hold_needs_tx_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(echo_hold) |-> $past(tx_en));

  a_r11_reenter_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_hold && mode_in[0]) |=> !echo_hold);
endmodule

bind uart_mode_router umr_checker #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .rxd_pin(rxd_pin),
  .tx_serial(tx_serial), .rx_bit_tick(rx_bit_tick), .rx_stop_seen(rx_stop_seen),
  .tx_en(tx_en), .rx_en(rx_en), .txd_pin(txd_pin), .rx_serial_in(rx_serial_in),
  .tx_clk_from_rx(tx_clk_from_rx), .rx_clk_from_tx(rx_clk_from_tx),
  .tx_rdy(tx_rdy), .tx_emt(tx_emt), .tx_wr(tx_wr),
  .rx_char_to_cpu(rx_char_to_cpu), .rx_check_en(rx_check_en),
  .rx_err(rx_err), .echo_hold(echo_hold)
);

// File: tb/sim_uart_mode_router.sv
module sim_uart_mode_router;
  localparam int ERR_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic rxd_pin = 1'b1, tx_serial = 1'b1, rx_bit_tick = 1'b0, rx_stop_seen = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b1, tx_rdy_raw = 1'b0, tx_emt_raw = 1'b0;
  logic cpu_tx_wr = 1'b0, rx_char_valid = 1'b0;
  logic [ERR_W-1:0] rx_err_raw = '0;
  logic txd_pin, rx_serial_in, tx_clk_from_rx, rx_clk_from_tx;
  logic tx_rdy, tx_emt, tx_wr, rx_char_to_cpu, rx_check_en, echo_hold;
  logic [ERR_W-1:0] rx_err;

  int checks = 0;
  int fails = 0;

  // Bench-side view of the routing state.
  logic [1:0] m_mode = 2'b00, m_hmode = 2'b00;
  logic m_hold = 1'b0, m_win = 1'b0, m_echo = 1'b1;

  always #5 clk = ~clk;

  uart_mode_router #(.ERR_W(ERR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .rxd_pin(rxd_pin),
    .tx_serial(tx_serial), .rx_bit_tick(rx_bit_tick), .rx_stop_seen(rx_stop_seen),
    .tx_en(tx_en), .rx_en(rx_en), .tx_rdy_raw(tx_rdy_raw), .tx_emt_raw(tx_emt_raw),
    .cpu_tx_wr(cpu_tx_wr), .rx_char_valid(rx_char_valid), .rx_err_raw(rx_err_raw),
    .txd_pin(txd_pin), .rx_serial_in(rx_serial_in), .tx_clk_from_rx(tx_clk_from_rx),
    .rx_clk_from_tx(rx_clk_from_tx), .tx_rdy(tx_rdy), .tx_emt(tx_emt), .tx_wr(tx_wr),
    .rx_char_to_cpu(rx_char_to_cpu), .rx_check_en(rx_check_en), .rx_err(rx_err),
    .echo_hold(echo_hold)
  );

  function automatic logic echoish(input logic [1:0] m);
    return m[0];  // codes 01 and 11 resend the line
  endfunction

  function automatic logic [12:0] expect_vec();
    logic [1:0] t;
    logic [12:0] v;
    t = m_hold ? m_hmode : m_mode;
    v[12] = (t == 2'b10) ? 1'b1 : (echoish(t) ? m_echo : tx_serial);
    v[11] = (m_mode == 2'b10) ? tx_serial : rxd_pin;
    v[10] = echoish(t);
    v[9]  = (m_mode == 2'b10);
    v[8]  = tx_rdy_raw & !echoish(t);
    v[7]  = tx_emt_raw & !echoish(t);
    v[6]  = cpu_tx_wr  & !echoish(t);
    v[5]  = rx_char_valid & (m_mode != 2'b11);
    v[4]  = (m_mode != 2'b11);
    v[3:1] = (m_mode == 2'b11) ? 3'b000 : rx_err_raw;
    v[0]  = m_hold;
    return v;
  endfunction

  function automatic logic [12:0] actual_vec();
    return {txd_pin, rx_serial_in, tx_clk_from_rx, rx_clk_from_tx, tx_rdy, tx_emt,
            tx_wr, rx_char_to_cpu, rx_check_en, rx_err, echo_hold};
  endfunction

  task automatic compare(input string req);
    checks++;
    if (actual_vec() !== expect_vec()) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, actual_vec(), expect_vec());
    end
  endtask

  // One clock: advance the bench model from the present inputs, then compare.
  task automatic cycle(input string req);
    logic defer, n_hold, n_win, n_echo;
    logic [1:0] n_hmode;
    defer   = echoish(m_mode) && !echoish(mode_in) && tx_en && (m_win || rx_stop_seen);
    n_hold  = defer ? 1'b1 : ((echoish(mode_in) || (rx_bit_tick && !rx_stop_seen)) ? 1'b0 : m_hold);
    n_hmode = defer ? m_mode : m_hmode;
    n_win   = rx_stop_seen ? 1'b1 : (rx_bit_tick ? 1'b0 : m_win);
    n_echo  = !rx_en ? 1'b1 : (rx_bit_tick ? rxd_pin : m_echo);
    @(posedge clk);
    m_mode = mode_in; m_hold = n_hold; m_hmode = n_hmode; m_win = n_win; m_echo = n_echo;
    #1;
    compare(req);
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Echo mode, send a data bit then a stop bit; exit in the given cycle.
  task automatic stop_then_exit(input logic [1:0] em, input logic txon, input bit exit_on_stop);
    mode_in = em; tx_en = txon; tx_rdy_raw = 1'b1; cpu_tx_wr = 1'b1; tx_serial = 1'b0;
    rx_bit_tick = 1'b1; rx_stop_seen = 1'b0; rxd_pin = 1'b0;
    cycle("R4");
    rxd_pin = 1'b1; rx_stop_seen = 1'b1;
    if (exit_on_stop) mode_in = 2'b00;
    cycle(txon ? "R8" : "R9");
    rx_bit_tick = 1'b0; rx_stop_seen = 1'b0; mode_in = 2'b00;
    cycle(txon ? "R8" : "R9");
    check_bit(txon ? "R8" : "R9", echo_hold, txon);
    cycle(txon ? "R8" : "R9");
    rx_bit_tick = 1'b1;
    cycle("R8");
    check_bit("R8", echo_hold, 1'b0);
    rx_bit_tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    check_bit("R1", txd_pin, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare("R1");

    // Sweep every mode over all data and status input patterns.
    for (int m = 0; m < 4; m++) begin
      mode_in = 2'(m);
      rx_bit_tick = 1'b1;
      for (int v = 0; v < 256; v++) begin
        rxd_pin = v[0]; tx_serial = v[1]; tx_rdy_raw = v[2]; tx_emt_raw = v[3];
        cpu_tx_wr = v[4]; rx_char_valid = v[5]; rx_err_raw = {v[6], v[7], v[6] ^ v[7]};
        cycle(mode_req(2'(m)));
        if (m[0]) check_bit("R4", txd_pin, v[0]);
      end
    end

    // R3: a new mode shows no effect until the next edge.
    mode_in = 2'b00; tx_serial = 1'b0; rx_bit_tick = 1'b0;
    cycle("R2");
    mode_in = 2'b10;
    #1;
    check_bit("R3", txd_pin, 1'b0);
    check_bit("R3", rx_clk_from_tx, 1'b0);
    cycle("R3");
    check_bit("R6", txd_pin, 1'b1);

    // R4: break level held across idle cycles without ticks.
    mode_in = 2'b01; rx_bit_tick = 1'b1; rxd_pin = 1'b0;
    cycle("R4");
    rx_bit_tick = 1'b0; rxd_pin = 1'b1;
    cycle("R4");
    check_bit("R4", txd_pin, 1'b0);

    // R10: receiver off forces mark on the echo.
    rx_en = 1'b0; rx_bit_tick = 1'b1; rxd_pin = 1'b0;
    cycle("R10");
    check_bit("R10", txd_pin, 1'b1);
    rx_en = 1'b1; rx_bit_tick = 1'b0;

    // R8: exits on the stop edge and in the window after it.
    stop_then_exit(2'b01, 1'b1, 1'b1);
    stop_then_exit(2'b01, 1'b1, 1'b0);
    stop_then_exit(2'b11, 1'b1, 1'b0);
    // R9: transmitter disabled means immediate exit.
    stop_then_exit(2'b01, 1'b0, 1'b0);
    stop_then_exit(2'b11, 1'b0, 1'b1);

    // R9: exit after an ordinary data tick is immediate.
    mode_in = 2'b01; tx_en = 1'b1; rx_bit_tick = 1'b1; rxd_pin = 1'b0;
    cycle("R9");
    rx_bit_tick = 1'b0; mode_in = 2'b10;
    cycle("R9");
    check_bit("R9", echo_hold, 1'b0);
    check_bit("R9", txd_pin, 1'b1);

    // R8 receive side follows at once; R11 re-entering echo clears hold.
    mode_in = 2'b11; rx_char_valid = 1'b1; rx_bit_tick = 1'b1; rx_stop_seen = 1'b1;
    cycle("R7");
    rx_bit_tick = 1'b0; rx_stop_seen = 1'b0; mode_in = 2'b00;
    cycle("R8");
    check_bit("R8", rx_char_to_cpu, 1'b1);
    check_bit("R8", echo_hold, 1'b1);
    mode_in = 2'b01;
    cycle("R11");
    check_bit("R11", echo_hold, 1'b0);
    cycle("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule